// File: doc/BRIEF.md
# Code Prefetch Queue Buffer

This block holds a small circular window of code bytes between an instruction decoder and a byte-wide code memory port. The decoder asks for 1, 2, 3 or 4 bytes at a linear address. The block answers from its window whenever enough bytes remain. It answers on a 32-bit bus, little-endian, with the unused upper bytes cleared.

When the window is empty, the block issues a burst refill. The burst starts at the requested address and runs up to the last slot of the aligned window. If a request asks for more bytes than remain, the block serves the leftover bytes first. It then refills at the following address and merges the missing bytes above them, so the decoder still receives one response. A flush, pulsed on a taken branch, discards the window contents. The decoder is expected to walk code sequentially between flushes, so each request address equals the previous address plus the previous size.

Top module: `code_prefetch_buf`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `rsp_valid` and `mem_req_valid` are 0. The window is treated as empty, so the first request starts a refill at its own address.
- R2: A request of `req_size` n (encoded 1 to 4; values 0 and 5 to 7 are not allowed) returns memory bytes addr to addr+n-1 on `rsp_data`. The byte at addr sits in bits 7:0 and each later byte is 8 bits higher. Bits from 8n upward are 0. `rsp_valid` is a single-cycle pulse.
- R3: A refill is requested only when the remaining-byte count is zero, either at the start of a request or after a partial read. `mem_req_addr` is the next byte address needed, and `mem_req_len` is QLEN - (address mod QLEN).
- R4: After a refill, the remaining count equals the refill length. Every byte handed out lowers it by one, and it never exceeds QLEN. A request that empties the window exactly causes no refill until the next request.
- R5: A 4-byte request with 1, 2 or 3 bytes remaining takes those bytes into the low positions. It then refills at addr + remaining and places the rest of the bytes above them.
- R6: A 2-byte request with 1 byte remaining takes the low byte, refills at addr + 1, and takes the high byte from the new fill.
- R7: `mem_req_valid` stays high with stable `mem_req_addr` and `mem_req_len` until `mem_req_ready`. The burst then takes exactly `mem_req_len` bytes, one per cycle with `mem_rsp_valid` high. Gaps between beats are allowed.
- R8: From the cycle after a request is accepted until its response, `busy` is 1 and `req_ready` is 0. When `rsp_valid` is high, `busy` is 0.
- R9: `flush` sampled while idle empties the window, so the next request refills at its own address.
- R10: A 3-byte request is served from the window like the other sizes and returns its three bytes in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Empty the window (sampled when idle) |
| req_valid | input | 1 | Code read request |
| req_addr | input | AW | Linear byte address of the request |
| req_size | input | 3 | Byte count, 1 to 4 |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | 32 | Little-endian bytes, unused upper bytes zero |
| busy | output | 1 | A request is in progress; the consumer is stalled |
| mem_req_valid | output | 1 | Refill request |
| mem_req_addr | output | AW | First byte address of the refill |
| mem_req_len | output | $clog2(QLEN)+1 | Number of bytes in the refill burst |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_rsp_valid | input | 1 | One refill byte is present |
| mem_rsp_data | input | 8 | Refill byte |

## Verification
The bench builds the block with QLEN = 8 instead of the default 16. With the shorter window, a walk of sequential requests reaches the window end every few requests, so all three 4-byte split cases and the 2-byte split occur many times. The short window also makes refills at odd offsets frequent and brings the exact-empty case within reach of a directed sequence. A randomized sequential walk with flushes then checks every response and every refill address and length against a model of the remaining count.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ASK   = 2'd2,
    ST_FILL  = 2'd3
  } cpq_state_e;
endpackage

// File: rtl/cpq_store.sv
module cpq_store #(
  parameter int QLEN = 16,
  localparam int IW = $clog2(QLEN)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_win
);
  logic [7:0] slot_q [QLEN];

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_byte;
  end

  for (genvar j = 0; j < 4; j++) begin : g_win
    logic [IW-1:0] ridx;
    assign ridx = rd_idx + IW'(j);
    assign rd_win[8*j +: 8] = slot_q[ridx];
  end
endmodule

// File: rtl/cpq_merge.sv
module cpq_merge (
  input  logic [31:0] acc_in,
  input  logic [31:0] win,
  input  logic [1:0]  pos,
  input  logic [2:0]  take,
  output logic [31:0] acc_out
);
  logic [2:0] lo, hi;
  assign lo = {1'b0, pos};
  assign hi = lo + take;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic       sel;
    logic [1:0] src;
    assign sel = (3'(b) >= lo) && (3'(b) < hi);
    assign src = 2'(b) - pos;
    assign acc_out[8*b +: 8] = sel ? win[8*src +: 8] : acc_in[8*b +: 8];
  end
endmodule

// File: rtl/code_prefetch_buf.sv
module code_prefetch_buf
  import cpq_pkg::*;
#(
  parameter int QLEN = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(QLEN),
  localparam int CW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          busy,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic [CW-1:0] mem_req_len,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data
);
  cpq_state_e    state_q, state_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [2:0]    left_q, left_n, size_q, size_n;
  logic [1:0]    pos_q, pos_n;
  logic [31:0]   acc_q, acc_n;
  logic [CW-1:0] remain_q, remain_n;
  logic [IW-1:0] fidx_q, fidx_n;
  logic          rsp_valid_q, rsp_valid_n;
  logic [31:0]   rsp_data_q, rsp_data_n;

  logic [IW-1:0] idx;
  logic [CW-1:0] fill_len;
  logic [2:0]    take;
  logic [31:0]   win, merged;
  logic          wr_en;

  assign idx      = addr_q[IW-1:0];
  assign fill_len = CW'(QLEN) - CW'(idx);
  assign take     = ({{(CW-3){1'b0}}, left_q} <= remain_q) ? left_q : remain_q[2:0];
  assign wr_en    = (state_q == ST_FILL) && mem_rsp_valid;

  cpq_store #(.QLEN(QLEN)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (fidx_q),
    .wr_byte (mem_rsp_data),
    .rd_idx  (idx),
    .rd_win  (win)
  );

  cpq_merge u_merge (
    .acc_in  (acc_q),
    .win     (win),
    .pos     (pos_q),
    .take    (take),
    .acc_out (merged)
  );

  always_comb begin
    state_n     = state_q;
    addr_n      = addr_q;
    left_n      = left_q;
    size_n      = size_q;
    pos_n       = pos_q;
    acc_n       = acc_q;
    remain_n    = remain_q;
    fidx_n      = fidx_q;
    rsp_valid_n = 1'b0;
    rsp_data_n  = rsp_data_q;
    unique case (state_q)
      ST_IDLE: begin
        if (flush) remain_n = '0;
        if (req_valid) begin
          addr_n  = req_addr;
          left_n  = req_size;
          size_n  = req_size;
          pos_n   = 2'd0;
          acc_n   = '0;
          state_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (remain_q == '0) begin
          state_n = ST_ASK;
        end else begin
          acc_n    = merged;
          left_n   = left_q - take;
          pos_n    = pos_q + take[1:0];
          addr_n   = addr_q + AW'(take);
          remain_n = remain_q - CW'(take);
          if (left_q == take) begin
            rsp_valid_n = 1'b1;
            rsp_data_n  = merged;
            state_n     = ST_IDLE;
          end else begin
            state_n = ST_ASK;
          end
        end
      end
      ST_ASK: begin
        if (mem_req_ready) begin
          fidx_n  = idx;
          state_n = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_rsp_valid) begin
          fidx_n = fidx_q + 1'b1;
          if (fidx_q == IW'(QLEN - 1)) begin
            remain_n = fill_len;
            state_n  = ST_CHECK;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      size_q      <= '0;
      pos_q       <= '0;
      acc_q       <= '0;
      remain_q    <= '0;
      fidx_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_n;
      addr_q      <= addr_n;
      left_q      <= left_n;
      size_q      <= size_n;
      pos_q       <= pos_n;
      acc_q       <= acc_n;
      remain_q    <= remain_n;
      fidx_q      <= fidx_n;
      rsp_valid_q <= rsp_valid_n;
      if (rsp_valid_n) rsp_data_q <= rsp_data_n;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (state_q == ST_ASK);
  assign mem_req_addr  = addr_q;
  assign mem_req_len   = fill_len;

  AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= CW'(QLEN)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_REFILL_DRY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> remain_q == '0); // R3
  AST_RSP_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (({32'd0, rsp_data} >> (6'd8 * {3'd0, size_q})) == 64'd0)); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy && req_ready); // R8
endmodule

// File: tb/code_prefetch_buf_test.sv
module code_prefetch_buf_test;
  localparam int QLEN = 8;
  localparam int AW   = 32;
  localparam int CW   = $clog2(QLEN) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_size = 3'd1;
  logic          req_ready, rsp_valid, busy, mem_req_valid;
  logic [31:0]   rsp_data;
  logic [AW-1:0] mem_req_addr;
  logic [CW-1:0] mem_req_len;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;

  int checks = 0;
  int fails = 0;
  int issued = 0;
  int seen = 0;
  int mrem = 0;
  bit done = 0;

  logic [31:0] exp_data_q[$];
  string       exp_tag_q[$];
  logic [AW-1:0] exp_ref_addr_q[$];
  int          exp_ref_len_q[$];
  string       ref_tag_q[$];

  always #10 clk = ~clk;

  code_prefetch_buf #(.QLEN(QLEN), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    logic [31:0] t;
    t = (a * 32'd13) ^ (a >> 8) ^ 32'h5C;
    return t[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pushes expected response and refills, then issues the request
  task automatic do_req(input logic [AW-1:0] a, input int n, input string tag);
    logic [31:0] ed = '0;
    logic [AW-1:0] cur = a;
    int left = n;
    for (int j = 0; j < n; j++) ed[8*j +: 8] = mb(a + AW'(j));
    exp_data_q.push_back(ed);
    exp_tag_q.push_back(tag);
    while (left > 0) begin
      if (mrem == 0) begin
        mrem = QLEN - int'(cur % QLEN);
        exp_ref_addr_q.push_back(cur);
        exp_ref_len_q.push_back(mrem);
        ref_tag_q.push_back(tag);
      end
      begin
        int k = (left < mrem) ? left : mrem;
        left -= k; mrem -= k; cur += AW'(k);
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 3'(n);
    issued++;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R8 busy after accept", {62'd0, busy, req_ready}, 64'h2);
    while (seen < issued) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mrem = 0;
  endtask

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      seen++;
      if (exp_data_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", {32'd0, rsp_data}, 64'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_data_q.pop_front();
        t = exp_tag_q.pop_front();
        chk(rsp_data == e, t, {32'd0, rsp_data}, {32'd0, e});
      end
    end
  end

  // memory model: accepts refill after a delay, streams bytes with gaps
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [AW-1:0] ra;
        int rl;
        repeat ($urandom % 3) @(negedge clk);
        ra = mem_req_addr;
        rl = int'(mem_req_len);
        if (exp_ref_addr_q.size() == 0) begin
          chk(1'b0, "R3 unexpected refill", {32'd0, ra}, 64'd0);
        end else begin
          logic [AW-1:0] ea;
          int el;
          string t;
          ea = exp_ref_addr_q.pop_front();
          el = exp_ref_len_q.pop_front();
          t = ref_tag_q.pop_front();
          chk(ra == ea, {"R3 refill addr ", t}, {32'd0, ra}, {32'd0, ea});
          chk(rl == el, {"R3 refill len ", t}, 64'(rl), 64'(el));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int b = 0; b < rl; b++) begin
          repeat ($urandom % 2) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mb(ra + AW'(b));
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          chk(b == rl - 1 || busy, "R7 busy during burst", {63'd0, busy}, 64'd1);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", seen, issued);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !rsp_valid && !mem_req_valid, "R1 reset state",
        {60'd0, req_ready, busy, rsp_valid, mem_req_valid}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R1 idle after reset", {62'd0, req_ready, busy}, 64'h2);
    // first request refills at its own offset, then splits (3 left) -> R1, R5
    do_req(32'h105, 4, "R5 split with 3 remaining");
    do_req(32'h109, 2, "R2 word hit");
    do_req(32'h10B, 3, "R10 three-byte hit");
    do_req(32'h10E, 4, "R5 split with 2 remaining");
    do_req(32'h112, 4, "R2 dword hit");
    do_req(32'h116, 1, "R2 byte hit");
    do_req(32'h117, 4, "R5 split with 1 remaining");
    do_req(32'h11B, 2, "R2 word hit");
    do_req(32'h11D, 2, "R2 word hit");
    do_req(32'h11F, 2, "R6 word split with 1 remaining");
    do_req(32'h121, 4, "R4 dword hit");
    do_req(32'h125, 3, "R4 exact empty");
    do_req(32'h128, 1, "R4 refill after exact empty");
    do_flush();
    do_req(32'h2003, 4, "R9 refill after flush");
    do_req(32'h2007, 1, "R9 byte after flush refill");
    // randomized sequential walk with occasional flushes
    begin
      logic [AW-1:0] a = 32'h3001;
      for (int i = 0; i < 300; i++) begin
        int n = 1 + int'($urandom % 4);
        if (($urandom % 23) == 0) begin
          do_flush();
          a = 32'h4000 + AW'($urandom % 64);
        end
        do_req(a, n, (n == 3) ? "R10 walk" : "R2 walk");
        a += AW'(n);
      end
    end
    repeat (5) @(negedge clk);
    chk(exp_data_q.size() == 0, "R2 all responses seen", 64'(exp_data_q.size()), 64'd0);
    chk(exp_ref_addr_q.size() == 0, "R3 all refills seen", 64'(exp_ref_addr_q.size()), 64'd0);
    chk(!busy && req_ready, "R8 idle at end", {62'd0, busy, req_ready}, 64'h1);
    finish_run();
  end
endmodule